// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Adapter

This adapter sits between a peripheral that moves data sixteen bits at a time and a byte-addressed memory request port. A transfer is started with a start address, a byte count, a direction and a pass-through flag. Every memory address is formed by OR-ing the request address with a base value held in an upper-address register. That register is loaded through a separate configuration strobe.

In swap mode the adapter clears bit 0 of the merged address and of the byte count. It then exchanges the two bytes of every halfword it carries, in both directions. In pass-through mode address, count and data are used exactly as given, and an odd count ends in a single-byte beat.

Writes (peripheral to memory) go out as bursts. In swap mode a burst closes every 64 bytes counted from the start address. Reads (memory to peripheral) keep one memory beat in flight at a time. A one-cycle completion pulse follows the last beat. A level interrupt from the peripheral is forwarded on a registered output.

Top module: `hws_dma_adapter`

## Requirements
- R1: After reset, `req_ready` is 1; `mem_valid`, `pdi_ready`, `pdo_valid`, `done` and `irq_out` are 0; and the base register holds 0.
- R2: The first beat address is `req_addr | base`, with bit 0 forced to 0 in swap mode (`req_raw`=0). Each later beat address is 2 above the one before it.
- R3: In pass-through mode (`req_raw`=1) the byte count is used unchanged and data passes unmodified. Every beat has `mem_be`=2'b11, except that an odd count makes the final beat `mem_be`=2'b01. Bit 0 of `mem_be` is the byte at the lower address, carried in data bits [7:0].
- R4: In swap mode bit 0 of the byte count is cleared. Each halfword leaves with its bytes exchanged: output[15:8]=input[7:0] and output[7:0]=input[15:8]. This holds for writes (`pdi_data` to `mem_wdata`) and for reads (`mem_rdata` to `pdo_data`).
- R5: On swap-mode writes, `mem_blast` is 1 on the final beat and on every beat that ends a 64-byte block counted from the start address. On pass-through writes and on all reads, `mem_blast` is 1 only on the final beat.
- R6: A read issues one memory beat (`mem_we`=0). The adapter then waits for `mem_rvalid`/`mem_rready` and delivers that data on `pdo_data` before it issues the next beat. While `mem_valid` waits for `mem_ready`, the beat's address and data stay stable.
- R7: A request whose byte count is zero after alignment (for example count 1 in swap mode) issues no memory or peripheral beat. For such a request, `done` is 1 in the cycle after acceptance.
- R8: `done` is a single-cycle pulse. It comes in the cycle after the final write beat is accepted by memory, or in the cycle after the final read halfword is taken by the peripheral. A new request is taken only while `req_ready` is 1.
- R9: `irq_out` equals the value `periph_irq` had at the previous clock edge.
- R10: `cfg_we` loads `cfg_base` into the base register. The base is sampled when a request is accepted, so a load made during a transfer affects only later requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the base register |
| cfg_base | input | ADDR_W | New base value |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Adapter idle and taking a request |
| req_addr | input | ADDR_W | Start address before merging |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_raw | input | 1 | 1: pass-through, 0: swap mode |
| pdi_valid | input | 1 | Peripheral write halfword valid |
| pdi_ready | output | 1 | Adapter takes write halfword |
| pdi_data | input | 16 | Write halfword from peripheral |
| pdo_valid | output | 1 | Read halfword valid for peripheral |
| pdo_ready | input | 1 | Peripheral takes read halfword |
| pdo_data | output | 16 | Read halfword to peripheral |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts beat |
| mem_we | output | 1 | 1: write beat, 0: read beat |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_be | output | 2 | Byte enables, bit 0 = lower address |
| mem_wdata | output | 16 | Write data |
| mem_blast | output | 1 | Last beat of a burst |
| mem_rvalid | input | 1 | Read response valid |
| mem_rready | output | 1 | Adapter takes read response |
| mem_rdata | input | 16 | Read response data |
| done | output | 1 | Transfer complete pulse |
| periph_irq | input | 1 | Peripheral interrupt level |
| irq_out | output | 1 | Registered interrupt level |

## Verification
The assertions rely on the neighbours following the handshake rules. Each valid is held, with its data, until the matching ready is seen. A read response arrives only after a read beat has been accepted. Only one read response is ever pending. The bench keeps within these rules. Its memory responder raises `mem_rvalid` only after it has seen a read beat accepted, and lowers it only after the handshake. Its peripheral and request drivers change a payload only in the cycle after that payload has been taken. Ready signals are randomised only on the ready side, so the adapter's own valids are never forced to drop.

// File: rtl/hws_pkg.sv
package hws_pkg;

    localparam int HW_DATA_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PERI,
        ST_WR_MEM,
        ST_RD_MEM,
        ST_RD_RESP,
        ST_RD_PERI,
        ST_FIN
    } hws_state_e;

    typedef struct packed {
        logic       final_b;
        logic       blast;
        logic [1:0] be;
    } beat_flags_t;

endpackage

// File: rtl/hws_swap.sv
module hws_swap #(
    parameter int DATA_W = 16
) (
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int HALVES = DATA_W / 16;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign dout[h*16 +: 16] = en ? {din[h*16 +: 8], din[h*16+8 +: 8]}
                                     : din[h*16 +: 16];
    end
endmodule

// File: rtl/hws_beat_gen.sv
module hws_beat_gen
    import hws_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int BURST_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              ld_raw,
    input  logic              ld_write,
    output logic [ADDR_W-1:0] beat_addr,
    output beat_flags_t       flags,
    output logic              cur_raw,
    output logic              eff_zero
);
    localparam int OFF_W = $clog2(BURST_BYTES);
    localparam logic [OFF_W-1:0]  LAST_OFF  = OFF_W'(BURST_BYTES - 2);
    localparam logic [OFF_W-1:0]  OFF_STEP  = OFF_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(2);
    localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(2);
    localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);

    logic [ADDR_W-1:0] eff_addr, addr_q;
    logic [LEN_W-1:0]  eff_len, rem_q;
    logic [OFF_W-1:0]  off_q;
    logic              raw_q, wr_q;

    assign eff_addr = ld_raw ? ld_addr : {ld_addr[ADDR_W-1:1], 1'b0};
    assign eff_len  = ld_raw ? ld_len  : {ld_len[LEN_W-1:1], 1'b0};
    assign eff_zero = (eff_len == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
            off_q  <= '0;
            raw_q  <= 1'b0;
            wr_q   <= 1'b0;
        end else if (load) begin
            addr_q <= eff_addr;
            rem_q  <= eff_len;
            off_q  <= '0;
            raw_q  <= ld_raw;
            wr_q   <= ld_write;
        end else if (step) begin
            addr_q <= addr_q + ADDR_STEP;
            rem_q  <= rem_q - LEN_STEP;
            off_q  <= off_q + OFF_STEP;
        end
    end

    always_comb begin
        flags.final_b = (rem_q <= LEN_STEP);
        flags.be      = (rem_q == LEN_ONE) ? 2'b01 : 2'b11;
        flags.blast   = flags.final_b | (wr_q & ~raw_q & (off_q == LAST_OFF));
    end

    assign beat_addr = addr_q;
    assign cur_raw   = raw_q;

    p_step_nonfinal_r8: assert property (@(posedge clk) disable iff (rst)
        step |-> !flags.final_b);
endmodule

// File: rtl/hws_ctrl.sv
module hws_ctrl
    import hws_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_zero,
    input  logic req_write,
    input  logic pdi_valid,
    input  logic mem_ready,
    input  logic mem_rvalid,
    input  logic pdo_ready,
    input  logic beat_final,
    output logic req_ready,
    output logic pdi_ready,
    output logic mem_valid,
    output logic mem_we,
    output logic mem_rready,
    output logic pdo_valid,
    output logic done,
    output logic load,
    output logic step,
    output logic cap_w,
    output logic cap_r
);
    hws_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                if (req_zero)       state_d = ST_FIN;
                else if (req_write) state_d = ST_WR_PERI;
                else                state_d = ST_RD_MEM;
            end
            ST_WR_PERI: if (pdi_valid)  state_d = ST_WR_MEM;
            ST_WR_MEM:  if (mem_ready)  state_d = beat_final ? ST_FIN : ST_WR_PERI;
            ST_RD_MEM:  if (mem_ready)  state_d = ST_RD_RESP;
            ST_RD_RESP: if (mem_rvalid) state_d = ST_RD_PERI;
            ST_RD_PERI: if (pdo_ready)  state_d = beat_final ? ST_FIN : ST_RD_MEM;
            ST_FIN:                     state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign pdi_ready  = (state_q == ST_WR_PERI);
    assign mem_valid  = (state_q == ST_WR_MEM) || (state_q == ST_RD_MEM);
    assign mem_we     = (state_q == ST_WR_MEM);
    assign mem_rready = (state_q == ST_RD_RESP);
    assign pdo_valid  = (state_q == ST_RD_PERI);
    assign done       = (state_q == ST_FIN);
    assign load       = req_ready & req_valid;
    assign cap_w      = pdi_ready & pdi_valid;
    assign cap_r      = mem_rready & mem_rvalid;
    assign step       = ((state_q == ST_WR_MEM) & mem_ready & ~beat_final)
                      | (pdo_valid & pdo_ready & ~beat_final);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_valid && !pdo_valid && !pdi_ready);

    p_one_read_r6: assert property (@(posedge clk) disable iff (rst)
        mem_rready |-> !mem_valid && !pdo_valid);
endmodule

// File: rtl/hws_dma_adapter.sv
module hws_dma_adapter
    import hws_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 16,
    parameter int BURST_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic              req_raw,
    input  logic              pdi_valid,
    output logic              pdi_ready,
    input  logic [15:0]       pdi_data,
    output logic              pdo_valid,
    input  logic              pdo_ready,
    output logic [15:0]       pdo_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    output logic              mem_blast,
    input  logic              mem_rvalid,
    output logic              mem_rready,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    input  logic              periph_irq,
    output logic              irq_out
);
    logic [ADDR_W-1:0]    base_q;
    logic                 irq_q;
    logic                 load, step, cap_w, cap_r, eff_zero, cur_raw;
    logic [ADDR_W-1:0]    beat_addr;
    beat_flags_t          flags;
    logic [HW_DATA_W-1:0] w_sw, r_sw, wbuf_q, rbuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= periph_irq;
            if (cfg_we) base_q <= cfg_base;
        end
    end

    hws_beat_gen #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)
    ) u_beat (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .ld_addr(req_addr | base_q), .ld_len(req_len),
        .ld_raw(req_raw), .ld_write(req_write),
        .beat_addr(beat_addr), .flags(flags),
        .cur_raw(cur_raw), .eff_zero(eff_zero)
    );

    hws_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_zero(eff_zero), .req_write(req_write),
        .pdi_valid(pdi_valid), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .pdo_ready(pdo_ready), .beat_final(flags.final_b),
        .req_ready(req_ready), .pdi_ready(pdi_ready), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_rready(mem_rready), .pdo_valid(pdo_valid),
        .done(done), .load(load), .step(step), .cap_w(cap_w), .cap_r(cap_r)
    );

    hws_swap #(.DATA_W(HW_DATA_W)) u_swap_wr (.en(~cur_raw), .din(pdi_data),  .dout(w_sw));
    hws_swap #(.DATA_W(HW_DATA_W)) u_swap_rd (.en(~cur_raw), .din(mem_rdata), .dout(r_sw));

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q <= '0;
            rbuf_q <= '0;
        end else begin
            if (cap_w) wbuf_q <= w_sw;
            if (cap_r) rbuf_q <= r_sw;
        end
    end

    assign mem_addr  = beat_addr;
    assign mem_be    = flags.be;
    assign mem_blast = flags.blast;
    assign mem_wdata = wbuf_q;
    assign pdo_data  = rbuf_q;
    assign irq_out   = irq_q;

    p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_out == $past(periph_irq));

    p_addr_even_r2: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !cur_raw |-> !mem_addr[0]);

    p_hold_beat_r6: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

    p_partial_be_r3: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_be != 2'b11 |-> cur_raw && mem_blast);
endmodule

// File: tb/hws_dma_adapter_tb.sv
module hws_dma_adapter_tb;
    localparam int AW = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst, cfg_we, req_valid, req_ready, req_write, req_raw;
    logic [AW-1:0] cfg_base, req_addr, mem_addr;
    logic [LW-1:0] req_len;
    logic          pdi_valid, pdi_ready, pdo_valid, pdo_ready;
    logic [15:0]   pdi_data, pdo_data, mem_wdata, mem_rdata;
    logic          mem_valid, mem_ready, mem_we, mem_blast, mem_rvalid, mem_rready;
    logic [1:0]    mem_be;
    logic          done, periph_irq, irq_out;

    hws_dma_adapter u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_raw(req_raw),
        .pdi_valid(pdi_valid), .pdi_ready(pdi_ready), .pdi_data(pdi_data),
        .pdo_valid(pdo_valid), .pdo_ready(pdo_ready), .pdo_data(pdo_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_blast(mem_blast), .mem_rvalid(mem_rvalid), .mem_rready(mem_rready),
        .mem_rdata(mem_rdata), .done(done), .periph_irq(periph_irq), .irq_out(irq_out)
    );

    typedef struct { logic [31:0] addr; int len; bit write; bit raw; } treq_t;
    typedef struct { logic [31:0] addr; logic we; logic [1:0] be; logic [15:0] wdata; logic blast; } tbeat_t;

    treq_t       req_q[$];
    logic [31:0] cfg_q[$];
    tbeat_t      exp_mem[$];
    logic [15:0] exp_pdo[$];
    logic [15:0] wq[$];

    int          checks = 0, fails = 0, completed = 0;
    bit          finished = 0, run_en = 0, busy = 0, cur_raw_m = 0;
    bit          exp_done_next = 0, exp_done_now = 0;
    bit          pdi_fire_prev = 0, rv_fire_prev = 0, req_fire_prev = 0, rd_pend = 0;
    bit          cur_zero = 0;
    logic [31:0] tb_base = '0, rd_addr = '0;
    logic        irq_prev = 1'b0;
    treq_t       cur_r;
    tbeat_t      eb;

    function automatic logic [15:0] swp(logic [15:0] d);
        return {d[7:0], d[15:8]};
    endfunction

    function automatic logic [15:0] rmem(logic [31:0] a);
        return {a[7:0], a[7:0] ^ 8'h3C};
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic present(treq_t r);
        logic [31:0] a;
        int L, nb;
        a = r.addr | tb_base;
        if (!r.raw) a[0] = 1'b0;
        L  = r.raw ? r.len : (r.len & ~1);
        nb = (L + 1) / 2;
        cur_raw_m = r.raw;
        cur_zero  = (nb == 0);
        for (int i = 0; i < nb; i++) begin
            tbeat_t b;
            logic [15:0] w;
            b.addr  = a + 32'(2 * i);
            b.we    = r.write;
            b.be    = (r.raw && (L % 2 == 1) && i == nb - 1) ? 2'b01 : 2'b11;
            b.blast = (i == nb - 1) || (r.write && !r.raw && ((2 * i + 2) % 64 == 0));
            w       = 16'($urandom);
            b.wdata = r.raw ? w : swp(w);
            if (r.write) wq.push_back(w);
            else exp_pdo.push_back(r.raw ? rmem(b.addr) : swp(rmem(b.addr)));
            exp_mem.push_back(b);
        end
        req_valid = 1'b1;
        req_addr  = r.addr;
        req_len   = LW'(r.len);
        req_write = r.write;
        req_raw   = r.raw;
    endtask

    // Behavioural reference model, evaluated once per clock at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (run_en) begin
                exp_done_now  = exp_done_next;
                exp_done_next = 0;
                chk("R8", "done", {31'b0, done}, {31'b0, exp_done_now});
                if (exp_done_now) begin
                    busy = 0;
                    completed++;
                    chk("R8", "beats left at done", 32'(exp_mem.size() + exp_pdo.size()), 0);
                end
                chk("R9", "irq_out", {31'b0, irq_out}, {31'b0, irq_prev});
                periph_irq = 1'($urandom);
                irq_prev   = periph_irq;

                if (req_fire_prev) begin req_valid = 1'b0; req_fire_prev = 0; end
                if (!busy && !req_valid && req_q.size() > 0 && req_ready) begin
                    cur_r = req_q.pop_front();
                    present(cur_r);
                    busy = 1;
                end
                if (cfg_we) cfg_we = 1'b0;
                if (cfg_q.size() > 0) begin
                    cfg_base = cfg_q.pop_front();
                    cfg_we   = 1'b1;
                    tb_base  = cfg_base;
                end

                if (rv_fire_prev) begin mem_rvalid = 1'b0; rv_fire_prev = 0; end
                if (rd_pend && !mem_rvalid) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rmem(rd_addr);
                    rd_pend    = 0;
                end
                mem_ready = ($urandom % 4) != 0;
                pdo_ready = ($urandom % 3) != 0;
                if (pdi_fire_prev) begin pdi_valid = 1'b0; pdi_fire_prev = 0; end
                if (!pdi_valid && wq.size() > 0 && ($urandom % 2) == 1) begin
                    pdi_valid = 1'b1;
                    pdi_data  = wq.pop_front();
                end

                if (req_valid && req_ready) begin
                    req_fire_prev = 1;
                    if (cur_zero) exp_done_next = 1;
                end
                if (mem_valid && mem_ready) begin
                    if (exp_mem.size() == 0) begin
                        chk("R7", "unexpected memory beat", mem_addr, 32'hFFFF_FFFF);
                    end else begin
                        eb = exp_mem.pop_front();
                        chk("R2", "mem_addr", mem_addr, eb.addr);
                        chk("R6", "mem_we", {31'b0, mem_we}, {31'b0, eb.we});
                        chk("R3", "mem_be", {30'b0, mem_be}, {30'b0, eb.be});
                        chk("R5", "mem_blast", {31'b0, mem_blast}, {31'b0, eb.blast});
                        if (eb.we) chk(cur_raw_m ? "R3" : "R4", "mem_wdata", {16'b0, mem_wdata}, {16'b0, eb.wdata});
                        if (!mem_we) begin rd_pend = 1; rd_addr = mem_addr; end
                        else if (exp_mem.size() == 0) exp_done_next = 1;
                    end
                end
                if (pdo_valid && pdo_ready) begin
                    if (exp_pdo.size() == 0) begin
                        chk("R6", "unexpected read halfword", {16'b0, pdo_data}, 32'hFFFF_FFFF);
                    end else begin
                        chk(cur_raw_m ? "R3" : "R4", "pdo_data", {16'b0, pdo_data}, {16'b0, exp_pdo.pop_front()});
                        if (exp_pdo.size() == 0) exp_done_next = 1;
                    end
                end
                if (pdi_valid && pdi_ready)   pdi_fire_prev = 1;
                if (mem_rvalid && mem_rready) rv_fire_prev  = 1;
            end
        end
    end

    task automatic push_req(logic [31:0] a, int len, bit wr, bit raw);
        treq_t r;
        r.addr = a; r.len = len; r.write = wr; r.raw = raw;
        req_q.push_back(r);
    endtask

    task automatic wait_done(int target);
        wait (completed >= target);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", completed, 15);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_base = '0; req_valid = 1'b0;
        req_addr = '0; req_len = '0; req_write = 1'b0; req_raw = 1'b0;
        pdi_valid = 1'b0; pdi_data = '0; pdo_ready = 1'b0; mem_ready = 1'b0;
        mem_rvalid = 1'b0; mem_rdata = '0; periph_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "req_ready", {31'b0, req_ready}, 1);
        chk("R1", "mem_valid", {31'b0, mem_valid}, 0);
        chk("R1", "pdi_ready", {31'b0, pdi_ready}, 0);
        chk("R1", "pdo_valid", {31'b0, pdo_valid}, 0);
        chk("R1", "done", {31'b0, done}, 0);
        chk("R1", "irq_out", {31'b0, irq_out}, 0);
        run_en = 1;

        // R1 base zero, R4 swap write, R3 pass-through odd write
        push_req(32'h0000_0100, 8, 1, 0);  wait_done(1);
        push_req(32'h0000_0201, 5, 1, 1);  wait_done(2);
        // R4 swap read with odd addr/len, R3 pass-through read odd length
        push_req(32'h0000_0301, 7, 0, 0);  wait_done(3);
        push_req(32'h0000_0400, 3, 0, 1);  wait_done(4);
        // R5 swapped write across 64-byte blocks, pass-through long write
        push_req(32'h0000_1000, 150, 1, 0); wait_done(5);
        push_req(32'h0000_2000, 130, 1, 1); wait_done(6);
        // R7 zero after alignment and true zero
        push_req(32'h0000_3000, 1, 1, 0);  wait_done(7);
        push_req(32'h0000_3001, 0, 0, 1);  wait_done(8);
        // R10 base merge, R2 bit 0 cleared after merge
        cfg_q.push_back(32'h0001_0000);
        push_req(32'h0000_0040, 4, 1, 0);  wait_done(9);
        cfg_q.push_back(32'h0000_8001);
        push_req(32'h0000_0050, 6, 0, 0);  wait_done(10);
        push_req(32'h0000_0050, 3, 1, 1);  wait_done(11);
        // R10 base loaded during a transfer affects only the next request
        cfg_q.push_back(32'h0000_0000);
        push_req(32'h0000_4000, 40, 0, 0);
        wait (busy == 1);
        cfg_q.push_back(32'h0100_0000);
        push_req(32'h0000_5002, 6, 1, 0);  wait_done(13);
        // R6 longer swapped read with backpressure
        push_req(32'h0000_6000, 70, 0, 0); wait_done(14);
        push_req(32'h0000_7000, 2, 1, 1);  wait_done(15);
        repeat (5) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule